// File: doc/BRIEF.md
# GCR Read Bitstream Generator

This block produces the serial read line that a host floppy controller decodes. Bytes are drawn from the emulator side and sent most significant bit first, one bit cell per bit. A one is sent as a level change at the start of its cell and a zero as a cell without any change. The cell lasts a fixed, parameterised number of clock cycles. Bytes follow one another with no padding. Every byte is expected to have its top bit set, so the host can find byte edges from the bit stream alone.

A sector frame begins only when the emulator asks for it, and the request is looked at only where one word ends and the next begins. The frame is a fixed run of ten-bit self-synchronising words (eight ones, then two zeros), then the three header mark bytes D5, AA and 96, then the payload bytes, which arrive through a valid/ready handshake until a byte flagged as last. Between frames, and wherever a payload byte is not ready in time, the line carries sync words without a break. To the host this looks like a longer inter-sector gap.

The block also reports which sector number the emulator should put into the next frame. It steps through a two-way interleaved order of the track's sectors, and the order repeats.

Top module: `gcr_read_stream`

## Requirements
- R1: While reset is applied, and until the first cell after it begins, `rd_o` is low, `byte_ready_o` is low and `sector_o` is 0.
- R2: Every level change on `rd_o` falls on a cell boundary, and cells are CELL_CYCLES clock cycles apart. A cell carrying a one starts with a change of `rd_o` and a cell carrying a zero has none. Each word is sent most significant bit first, and a word follows the previous one with no idle cell between them.
- R3: While no frame is requested, the line carries back-to-back sync words, each the ten bits 1111111100.
- R4: `sector_req_i` is acted on only at a word boundary. The word already in progress is always finished, and a frame's first sync word begins in the cycle that `sector_o` advances.
- R5: A frame consists of exactly SYNC_MIN sync words, then D5, AA, 96 in that order, then the accepted payload bytes in the order they were accepted.
- R6: `byte_ready_o` is high for exactly one cycle: the first cycle of the last cell of a word that precedes a payload slot. A byte is taken when `byte_valid_i` and `byte_ready_o` are both high at a clock edge. Bytes streamed without a pause are therefore taken 8 cells apart.
- R7: If no byte is taken for a payload slot, the slot is filled with one sync word and the handshake is offered again at the last cell of that word. The frame then goes on with the next byte taken.
- R8: After the byte flagged by `byte_last_i` has been sent, the line returns to sync words until the next request is seen.
- R9: `sector_o` starts at 0 and advances by one step each time a frame starts. With SECTORS=12 the order is 0 6 1 7 2 8 3 9 4 10 5 11, and then the order repeats. In general, step k gives k/2 when k is even and k/2 + SECTORS/2 when k is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, CELL_CYCLES cycles per cell |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sector_req_i | input | 1 | Level request to start a sector frame, examined at word boundaries |
| byte_valid_i | input | 1 | A payload byte is offered |
| byte_i | input | 8 | Payload byte, top bit expected set |
| byte_last_i | input | 1 | The offered byte ends the frame |
| byte_ready_o | output | 1 | One-cycle pulse, a byte may be taken at this edge |
| rd_o | output | 1 | Transition-coded serial read line |
| sector_o | output | $clog2(SECTORS) | Sector number to place in the next frame |

## Verification
The bench builds the block with CELL_CYCLES=4, SYNC_MIN=5 and SECTORS=12. The short cell keeps each frame to a few hundred cycles, so thirteen frames fit easily, which is enough to walk the whole interleave order and see it repeat. The bench recovers the byte stream from the time between line changes, the same way a host would. It stalls the payload handshake on purpose so that filler words appear in mid-frame, and it raises requests at varying cycle offsets so that some arrive partway through a sync word. Payload values include 0x80, which has a run of seven zero cells.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  typedef enum logic [1:0] {
    PH_GAP  = 2'd0,
    PH_SYNC = 2'd1,
    PH_MARK = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

  localparam int WORD_W = 10;
  localparam int LEN_W  = 4;

  // Eight ones, two zeros, left aligned in the word register.
  localparam logic [WORD_W-1:0] SYNC_BITS = 10'b1111111100;
  localparam logic [LEN_W-1:0]  SYNC_LEN  = 4'd10;
  localparam logic [LEN_W-1:0]  BYTE_LEN  = 4'd8;

  typedef struct packed {
    logic [WORD_W-1:0] bits;
    logic [LEN_W-1:0]  len;
  } word_t;

  function automatic logic [7:0] mark_byte(input logic [1:0] sel);
    case (sel)
      2'd0:    mark_byte = 8'hD5;
      2'd1:    mark_byte = 8'hAA;
      default: mark_byte = 8'h96;
    endcase
  endfunction

endpackage

// File: rtl/gcr_cell_timer.sv
module gcr_cell_timer #(
  parameter int CELL_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic cell_end_o,
  output logic cell_first_o
);

  localparam int CW = (CELL_CYCLES > 1) ? $clog2(CELL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CELL_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cell_end_o   = (cnt_q == LAST);
    cell_first_o = (cnt_q == '0);
    cnt_d        = cell_end_o ? '0 : cnt_q + CW'(1);
  end

  // Reset to the last count so the first cell starts right after release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/gcr_word_shifter.sv
module gcr_word_shifter
  import gcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cell_end_i,
  input  word_t next_word_i,
  output logic  load_o,
  output logic  last_cell_o,
  output logic  rd_o
);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]  nb_q, nb_d;
  logic              rd_q, rd_d;

  always_comb begin
    load_o      = cell_end_i && (nb_q <= LEN_W'(1));
    last_cell_o = (nb_q == LEN_W'(1));
    sh_d = sh_q;
    nb_d = nb_q;
    rd_d = rd_q;
    if (load_o) begin
      sh_d = next_word_i.bits;
      nb_d = next_word_i.len;
      rd_d = rd_q ^ next_word_i.bits[WORD_W-1];
    end else if (cell_end_i) begin
      sh_d = {sh_q[WORD_W-2:0], 1'b0};
      nb_d = nb_q - LEN_W'(1);
      rd_d = rd_q ^ sh_q[WORD_W-2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      nb_q <= '0;
      rd_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      nb_q <= nb_d;
      rd_q <= rd_d;
    end
  end

  assign rd_o = rd_q;

endmodule

// File: rtl/gcr_frame_seq.sv
module gcr_frame_seq
  import gcr_pkg::*;
#(
  parameter int SYNC_MIN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       last_cell_i,
  input  logic       cell_first_i,
  input  logic       req_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  input  logic       last_i,
  output logic       ready_o,
  output logic       frame_start_o,
  output word_t      word_o
);

  localparam int SCW = $clog2(SYNC_MIN + 1);
  localparam logic [SCW-1:0] SYNC_TARGET = SCW'(SYNC_MIN);

  phase_e         ph_q, ph_d;
  logic [SCW-1:0] scnt_q, scnt_d;
  logic [1:0]     mcnt_q, mcnt_d;
  logic           hold_v_q, hold_v_d;
  logic [7:0]     hold_b_q, hold_b_d;
  logic           hold_l_q, hold_l_d;

  assign ready_o = (ph_q == PH_DATA) && cell_first_i && last_cell_i;

  always_comb begin
    ph_d          = ph_q;
    scnt_d        = scnt_q;
    mcnt_d        = mcnt_q;
    hold_v_d      = hold_v_q;
    hold_b_d      = hold_b_q;
    hold_l_d      = hold_l_q;
    frame_start_o = 1'b0;
    word_o.bits   = SYNC_BITS;
    word_o.len    = SYNC_LEN;

    if (ready_o && valid_i) begin
      hold_v_d = 1'b1;
      hold_b_d = data_i;
      hold_l_d = last_i;
    end

    if (load_i) begin
      unique case (ph_q)
        PH_GAP: begin
          if (req_i) begin
            frame_start_o = 1'b1;
            scnt_d        = SCW'(1);
            mcnt_d        = 2'd0;
            ph_d          = (SYNC_MIN <= 1) ? PH_MARK : PH_SYNC;
          end
        end
        PH_SYNC: begin
          scnt_d = scnt_q + SCW'(1);
          if (scnt_d >= SYNC_TARGET) begin
            ph_d   = PH_MARK;
            mcnt_d = 2'd0;
          end
        end
        PH_MARK: begin
          word_o.bits = {mark_byte(mcnt_q), 2'b00};
          word_o.len  = BYTE_LEN;
          mcnt_d      = mcnt_q + 2'd1;
          if (mcnt_q == 2'd2) ph_d = PH_DATA;
        end
        PH_DATA: begin
          if (hold_v_q) begin
            word_o.bits = {hold_b_q, 2'b00};
            word_o.len  = BYTE_LEN;
            hold_v_d    = 1'b0;
            if (hold_l_q) ph_d = PH_GAP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_GAP;
      scnt_q   <= '0;
      mcnt_q   <= '0;
      hold_v_q <= 1'b0;
      hold_b_q <= '0;
      hold_l_q <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      scnt_q   <= scnt_d;
      mcnt_q   <= mcnt_d;
      hold_v_q <= hold_v_d;
      hold_b_q <= hold_b_d;
      hold_l_q <= hold_l_d;
    end
  end

endmodule

// File: rtl/gcr_interleave.sv
module gcr_interleave #(
  parameter int SECTORS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv_i,
  output logic [$clog2(SECTORS)-1:0] sector_o
);

  localparam int IW = $clog2(SECTORS);
  localparam logic [IW-1:0] LAST = IW'(SECTORS - 1);
  localparam logic [IW-1:0] HALF = IW'(SECTORS / 2);

  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (adv_i) idx_d = (idx_q == LAST) ? '0 : idx_q + IW'(1);
    sector_o = idx_q[0] ? ((idx_q >> 1) + HALF) : (idx_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

endmodule

// File: rtl/gcr_read_stream.sv
module gcr_read_stream
  import gcr_pkg::*;
#(
  parameter int CELL_CYCLES = 16,
  parameter int SYNC_MIN    = 5,
  parameter int SECTORS     = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sector_req_i,
  input  logic                       byte_valid_i,
  input  logic [7:0]                 byte_i,
  input  logic                       byte_last_i,
  output logic                       byte_ready_o,
  output logic                       rd_o,
  output logic [$clog2(SECTORS)-1:0] sector_o
);

  localparam int SW = $clog2(SECTORS);

  logic [1:0] rsync_q;
  logic       rst_q;
  logic       cell_end, cell_first, load, last_cell, frame_start;
  word_t      next_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  gcr_cell_timer #(.CELL_CYCLES(CELL_CYCLES)) u_timer (
    .clk          (clk),
    .rst_n        (rst_q),
    .cell_end_o   (cell_end),
    .cell_first_o (cell_first)
  );

  gcr_word_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_q),
    .cell_end_i  (cell_end),
    .next_word_i (next_word),
    .load_o      (load),
    .last_cell_o (last_cell),
    .rd_o        (rd_o)
  );

  gcr_frame_seq #(.SYNC_MIN(SYNC_MIN)) u_seq (
    .clk           (clk),
    .rst_n         (rst_q),
    .load_i        (load),
    .last_cell_i   (last_cell),
    .cell_first_i  (cell_first),
    .req_i         (sector_req_i),
    .valid_i       (byte_valid_i),
    .data_i        (byte_i),
    .last_i        (byte_last_i),
    .ready_o       (byte_ready_o),
    .frame_start_o (frame_start),
    .word_o        (next_word)
  );

  gcr_interleave #(.SECTORS(SECTORS)) u_ilv (
    .clk      (clk),
    .rst_n    (rst_q),
    .adv_i    (frame_start),
    .sector_o (sector_o)
  );

endmodule

// File: rtl/gcr_read_stream_chk.sv
module gcr_read_stream_chk #(
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_q,
  input logic          rd_o,
  input logic          cell_first,
  input logic          load,
  input logic          byte_ready_o,
  input logic [SW-1:0] sector_o
);

  // R2
  rd_cell_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(rd_o) |-> cell_first);

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    byte_ready_o |=> !byte_ready_o);

  // R6
  ready_cell_chk: assert property (@(posedge clk) disable iff (!rst_q)
    byte_ready_o |-> cell_first);

  // R4
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(sector_o) |-> !$stable(rd_o));

  // R9
  sector_load_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(sector_o) |-> $past(load));

endmodule

bind gcr_read_stream gcr_read_stream_chk #(.SW(SW)) u_chk (
  .clk          (clk),
  .rst_q        (rst_q),
  .rd_o         (rd_o),
  .cell_first   (cell_first),
  .load         (load),
  .byte_ready_o (byte_ready_o),
  .sector_o     (sector_o)
);

// File: tb/sim_gcr_read_stream.sv
module sim_gcr_read_stream;

  localparam int CLK_PERIOD = 10;
  localparam int CELL = 4;
  localparam int SMIN = 5;
  localparam int NSEC = 12;
  localparam int SW   = $clog2(NSEC);
  localparam int WORD = 10 * CELL;
  localparam int WD_LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          sector_req = 1'b0;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_d = 8'h00;
  logic          byte_last = 1'b0;
  logic          byte_ready;
  logic          rd;
  logic [SW-1:0] sector;

  gcr_read_stream #(.CELL_CYCLES(CELL), .SYNC_MIN(SMIN), .SECTORS(NSEC)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .sector_req_i (sector_req),
    .byte_valid_i (byte_valid),
    .byte_i       (byte_d),
    .byte_last_i  (byte_last),
    .byte_ready_o (byte_ready),
    .rd_o         (rd),
    .sector_o     (sector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int frame_k = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_sec(input int k);
    int m;
    m = k % NSEC;
    return (m % 2 == 1) ? (m / 2 + NSEC / 2) : (m / 2);
  endfunction

  // Line decoder: rebuilds bits from the spacing of level changes.
  logic [7:0]    dlog [0:4095];
  int            nlog = 0;
  int            frame_idx [0:63];
  int            nframes = 0;
  int            last_tog = 0;
  bit            have_tog = 0;
  logic          rd_prev = 1'b0;
  logic [SW-1:0] sec_prev = '0;
  logic [7:0]    shreg = 8'h00;
  logic          rdy_prev = 1'b0;
  int            bad_cell = 0;
  int            bad_edge = 0;
  int            bad_rdy = 0;
  int            rdy_cnt = 0;
  int            tog_cnt = 0;

  function automatic void push_bit(input logic b);
    shreg = {shreg[6:0], b};
    if (shreg[7]) begin
      if (nlog < 4096) dlog[nlog] = shreg;
      nlog++;
      shreg = 8'h00;
    end
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (sector != sec_prev) begin
        // R4: frame starts right after a finished sync word (two zero cells)
        if (rd == rd_prev || !have_tog || (cyc - last_tog) != 3 * CELL) bad_edge++;
        if (nframes < 64) frame_idx[nframes] = nlog;
        nframes++;
      end
      if (rd != rd_prev) begin
        tog_cnt++;
        if (have_tog) begin
          int iv;
          iv = cyc - last_tog;
          if (iv % CELL != 0 || iv == 0) bad_cell++;
          for (int z = 1; z < iv / CELL; z++) push_bit(1'b0);
        end
        push_bit(1'b1);
        have_tog = 1;
        last_tog = cyc;
      end
      if (byte_ready) begin
        rdy_cnt++;
        if (rdy_prev) bad_rdy++;
      end
    end
    rd_prev  = rd;
    sec_prev = sector;
    rdy_prev = byte_ready;
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(rd == 1'b0, "R1 rd low in reset", rd, 0);
    check(byte_ready == 1'b0, "R1 ready low in reset", byte_ready, 0);
    check(sector == '0, "R1 sector zero in reset", sector, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd == 1'b0 && sector == '0, "R1 state right after release", {rd, sector}, 0);
  endtask

  task automatic t_idle();
    int a, r, allff;
    repeat (3 * WORD) @(negedge clk);
    a = nlog;
    r = rdy_cnt;
    repeat (20 * WORD) @(negedge clk);
    check(nlog - a >= 18, "R3 sync words while idle", nlog - a, 18);
    allff = 1;
    for (int i = a; i < nlog; i++) if (dlog[i] != 8'hFF) allff = 0;
    check(allff == 1, "R3 idle stream only sync words", allff, 1);
    check(rdy_cnt == r, "R3 no ready pulse while idle", rdy_cnt - r, 0);
    check(sector == '0 && nframes == 0, "R9 no advance without request", sector, 0);
  endtask

  task automatic t_frame(input int n, input int stall_at, input int stall_cyc);
    logic [7:0] d [0:15];
    int base, idx, p, ins, t, prev_acc;
    check(int'(sector) == exp_sec(frame_k), "R9 sector offered before frame", sector, exp_sec(frame_k));
    for (int i = 0; i < n; i++) begin
      d[i] = 8'h80 | 8'((i * 37 + frame_k * 11) & 8'h7f);
      if (d[i] == 8'hFF) d[i] = 8'hFE;
    end
    base = nframes;
    repeat ((frame_k * 7) % 37 + 1) @(negedge clk);
    sector_req = 1'b1;
    t = 0;
    while (nframes == base && t < 40 * WORD) begin @(negedge clk); t++; end
    sector_req = 1'b0;
    check(nframes == base + 1, "R4 frame accepted once", nframes - base, 1);
    prev_acc = -1;
    for (int i = 0; i < n; i++) begin
      if (i == stall_at) repeat (stall_cyc) @(negedge clk);
      byte_d = d[i];
      byte_last = (i == n - 1);
      byte_valid = 1'b1;
      t = 0;
      while (!byte_ready && t < 40 * WORD) begin @(negedge clk); t++; end
      if (prev_acc >= 0 && i != stall_at)
        check(cyc - prev_acc == 8 * CELL, "R6 back-to-back bytes 8 cells apart", cyc - prev_acc, 8 * CELL);
      prev_acc = cyc;
      @(negedge clk);
      byte_valid = 1'b0;
      byte_last = 1'b0;
    end
    repeat (6 * WORD) @(negedge clk);
    idx = frame_idx[base];
    for (int s = 0; s < SMIN; s++)
      check(dlog[idx + s] == 8'hFF, "R5 sync run", dlog[idx + s], 8'hFF);
    check(dlog[idx + SMIN] == 8'hD5, "R5 first mark", dlog[idx + SMIN], 8'hD5);
    check(dlog[idx + SMIN + 1] == 8'hAA, "R5 second mark", dlog[idx + SMIN + 1], 8'hAA);
    check(dlog[idx + SMIN + 2] == 8'h96, "R5 third mark", dlog[idx + SMIN + 2], 8'h96);
    p = idx + SMIN + 3;
    for (int i = 0; i < n; i++) begin
      if (i == stall_at) begin
        ins = 0;
        while (p < nlog && dlog[p] == 8'hFF) begin p++; ins++; end
        check(ins >= 1, "R7 filler sync inserted on stall", ins, 1);
      end
      check(dlog[p] == d[i], "R5 payload byte", dlog[p], d[i]);
      p++;
    end
    check(nlog >= p + 2 && dlog[p] == 8'hFF && dlog[p + 1] == 8'hFF,
          "R8 sync gap after last byte", dlog[p], 8'hFF);
    frame_k++;
  endtask

  initial begin
    #1;
    t_reset();
    t_idle();
    t_frame(4, -1, 0);
    t_frame(6, 3, 25 * CELL);
    for (int f = 0; f < 11; f++) t_frame(2, -1, 0);
    check(int'(sector) == exp_sec(frame_k), "R9 order wraps", sector, exp_sec(frame_k));
    check(bad_cell == 0 && tog_cnt > 100, "R2 changes only on cell boundaries", bad_cell, 0);
    check(bad_edge == 0, "R4 frame start on word boundary", bad_edge, 0);
    check(bad_rdy == 0, "R6 ready single-cycle", bad_rdy, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule